// File: doc/BRIEF.md
# DRAM Rank Refresh Sequencer

This block runs periodic refresh for one DRAM rank. A deadline register starts at tREFI after reset. The sequence opens tRP cycles before each deadline.

If the rank sits in a low-power state at that moment, a wake-up command is strobed first. The sequencer then waits out the exit latency: tXP after power-down, tXS after self-refresh. Next it waits for the rank's queued work to drain. If any bank is open, a precharge-all command is placed at the latest precharge-allowed time over the open banks. The refresh command follows once tRP has elapsed. After that, the rank either goes back to the low-power state it left or drops into precharge power-down.

Each command is a one-cycle strobe, raised in the cycle whose counter value equals the command time. With the precharge-all and with the refresh strobe, the block also presents a new activate-allowed time that applies to every bank. Each completed refresh advances the deadline by tREFI. If the advanced deadline falls before the refresh completion time, a sticky overrun flag is raised.

Top module: `rank_refresh_seq`

## Requirements
- R1: After reset, every command strobe, the activate-update strobe, busy and overrun are low. The first sequence opens when the cycle counter reaches tREFI minus tRP.
- R2: The sequence opens in the cycle where the counter equals the deadline minus tRP. busy_o is high from the next cycle until the cycle after completion.
- R3: While queue_busy_i is high, no command is issued. The drain step ends on the first cycle it samples queue_busy_i low.
- R4: With no bank open, precharge is skipped. The refresh strobe comes one cycle after the drain step ends.
- R5: With banks open, the precharge-all strobe fires at the later of two times: the largest precharge-allowed time among open banks (closed banks are ignored), and the cycle after the drain step ends. act_set_o is raised with it, and act_allow_o equals that cycle plus tRP.
- R6: The refresh strobe fires tRP cycles after the precharge-all strobe. act_set_o is raised with it, and act_allow_o equals the refresh cycle plus tRFC. Each strobe lasts one cycle.
- R7: Each refresh advances the deadline by tREFI. If the new deadline is earlier than the refresh cycle plus tRFC, overrun_o rises the next cycle and stays high until reset.
- R8: If pdn_i or sref_i is high when the sequence opens, wake_o pulses in the next cycle. The drain step starts tXP cycles after the wake (tXS if sref_i was high, which takes priority) plus one cycle. With no bank open and no queue activity, the refresh therefore lands at the wake cycle plus the exit time plus two.
- R9: In the completion cycle (refresh cycle plus tRFC), a rank that was in a low-power state gets lp_enter_o. lp_kind_o is 1 if that state was self-refresh and 0 if it was power-down.
- R10: A rank that was not in a low-power state gets lp_enter_o with lp_kind_o 0 in the completion cycle only if pd_en_i is high and queue_busy_i is low. Otherwise lp_enter_o stays low.
- R11: At most one of prea_o, ref_o, wake_o and lp_enter_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| now_i | input | TW | Free-running cycle counter |
| bank_open_i | input | NUM_BANKS | One bit per bank, high when the bank holds an open row |
| pre_allowed_i | input | NUM_BANKS*TW | Per-bank earliest precharge time, bank b at bits [b*TW +: TW] |
| queue_busy_i | input | 1 | Queued work pending for this rank |
| pdn_i | input | 1 | Rank is in power-down |
| sref_i | input | 1 | Rank is in self-refresh |
| pd_en_i | input | 1 | Power-down entry permitted after refresh |
| prea_o | output | 1 | Precharge-all command strobe |
| ref_o | output | 1 | Refresh command strobe |
| wake_o | output | 1 | Low-power exit command strobe |
| lp_enter_o | output | 1 | Low-power entry command strobe |
| lp_kind_o | output | 1 | Kind of entry: 0 precharge power-down, 1 self-refresh |
| act_set_o | output | 1 | Apply act_allow_o to all banks |
| act_allow_o | output | TW | New activate-allowed time |
| busy_o | output | 1 | Refresh sequence in progress |
| overrun_o | output | 1 | Sticky refresh deadline overrun |

## Verification
The sequence is driven along five entry paths:
- All banks closed with an idle queue, which isolates the skipped-precharge path.
- A mix of open and closed banks with scattered precharge-allowed times, which shows that only open banks set the precharge time.
- A queue held busy past the start, which separates drain gating from the deadline.
- Power-down entry, which distinguishes the shorter exit wait.
- Self-refresh entry, which distinguishes the longer exit wait and the restored low-power kind.

A final run uses an open bank whose precharge time is pushed past the deadline, so that completion overtakes the next deadline and the overrun flag must rise exactly one cycle after the refresh. Queue activity at completion tells the conditional power-down entry apart from the unconditional restore.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_EXIT,
    ST_DRAIN,
    ST_PRE,
    ST_RUN,
    ST_DONE
  } rrs_state_e;

  typedef enum logic [1:0] {
    LP_NONE,
    LP_PDN,
    LP_SREF
  } rrs_lp_e;
endpackage

// File: rtl/rrs_pre_max.sv
module rrs_pre_max #(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 32
) (
  input  logic [NUM_BANKS-1:0]    bank_open_i,
  input  logic [NUM_BANKS*TW-1:0] pre_allowed_i,
  output logic [TW-1:0]           max_o,
  output logic                    any_o
);
  logic [TW-1:0] cand [NUM_BANKS+1];

  assign cand[0] = '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TW-1:0] t_b;
    assign t_b        = pre_allowed_i[b*TW +: TW];
    assign cand[b+1]  = (bank_open_i[b] && (t_b > cand[b])) ? t_b : cand[b];
  end

  assign max_o = cand[NUM_BANKS];
  assign any_o = |bank_open_i;
endmodule

// File: rtl/rrs_deadline.sv
module rrs_deadline #(
  parameter int TW     = 32,
  parameter int T_REFI = 200,
  parameter int T_RP   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [TW-1:0] done_at_i,
  output logic [TW-1:0] start_at_o,
  output logic          overrun_o
);
  localparam logic [TW-1:0] REFI = TW'(T_REFI);
  localparam logic [TW-1:0] RP   = TW'(T_RP);

  logic [TW-1:0] deadline_q;
  logic [TW-1:0] deadline_nx;

  assign deadline_nx = deadline_q + REFI;
  assign start_at_o  = deadline_q - RP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deadline_q <= REFI;
      overrun_o  <= 1'b0;
    end else if (adv_i) begin
      deadline_q <= deadline_nx;
      if (deadline_nx < done_at_i) overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rrs_fsm.sv
module rrs_fsm
  import rrs_pkg::*;
#(
  parameter int TW    = 32,
  parameter int T_RP  = 5,
  parameter int T_RFC = 20,
  parameter int T_XP  = 3,
  parameter int T_XS  = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] now_i,
  input  logic [TW-1:0] start_at_i,
  input  logic [TW-1:0] pre_max_i,
  input  logic          any_open_i,
  input  logic          queue_busy_i,
  input  logic          pdn_i,
  input  logic          sref_i,
  input  logic          pd_en_i,
  output logic          prea_o,
  output logic          ref_o,
  output logic          wake_o,
  output logic          lp_enter_o,
  output logic          lp_kind_o,
  output logic          act_set_o,
  output logic [TW-1:0] act_allow_o,
  output logic [TW-1:0] done_at_o,
  output logic          busy_o
);
  localparam logic [TW-1:0] RP  = TW'(T_RP);
  localparam logic [TW-1:0] RFC = TW'(T_RFC);
  localparam logic [TW-1:0] XP  = TW'(T_XP);
  localparam logic [TW-1:0] XS  = TW'(T_XS);
  localparam logic [TW-1:0] ONE = TW'(1);

  rrs_state_e    st_q;
  rrs_lp_e       prior_q;
  logic [TW-1:0] pre_at_q, ref_at_q, done_at_q, exit_at_q;
  logic          lp_fire;

  assign wake_o      = (st_q == ST_WAKE);
  assign prea_o      = (st_q == ST_PRE) && (now_i >= pre_at_q);
  assign ref_o       = (st_q == ST_RUN) && (now_i >= ref_at_q);
  assign act_set_o   = prea_o | ref_o;
  assign act_allow_o = prea_o ? (pre_at_q + RP) : (ref_at_q + RFC);
  assign done_at_o   = ref_at_q + RFC;
  assign lp_fire     = (st_q == ST_DONE) && (now_i >= done_at_q);
  assign lp_enter_o  = lp_fire &&
                       ((prior_q != LP_NONE) || (pd_en_i && !queue_busy_i));
  assign lp_kind_o   = (prior_q == LP_SREF);
  assign busy_o      = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      prior_q   <= LP_NONE;
      pre_at_q  <= '0;
      ref_at_q  <= '0;
      done_at_q <= '0;
      exit_at_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (now_i >= start_at_i) begin
          if (sref_i) begin
            prior_q <= LP_SREF;
            st_q    <= ST_WAKE;
          end else if (pdn_i) begin
            prior_q <= LP_PDN;
            st_q    <= ST_WAKE;
          end else begin
            prior_q <= LP_NONE;
            st_q    <= ST_DRAIN;
          end
        end
        ST_WAKE: begin
          exit_at_q <= now_i + ((prior_q == LP_SREF) ? XS : XP);
          st_q      <= ST_EXIT;
        end
        ST_EXIT: if (now_i >= exit_at_q) st_q <= ST_DRAIN;
        ST_DRAIN: if (!queue_busy_i) begin
          if (any_open_i) begin
            pre_at_q <= (pre_max_i > now_i) ? pre_max_i : now_i + ONE;
            st_q     <= ST_PRE;
          end else begin
            ref_at_q <= now_i + ONE;
            st_q     <= ST_RUN;
          end
        end
        ST_PRE: if (prea_o) begin
          ref_at_q <= pre_at_q + RP;
          st_q     <= ST_RUN;
        end
        ST_RUN: if (ref_o) begin
          done_at_q <= ref_at_q + RFC;
          st_q      <= ST_DONE;
        end
        ST_DONE: if (lp_fire) begin
          prior_q <= LP_NONE;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rank_refresh_seq.sv
module rank_refresh_seq #(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 32,
  parameter int T_REFI    = 200,
  parameter int T_RFC     = 20,
  parameter int T_RP      = 5,
  parameter int T_XP      = 3,
  parameter int T_XS      = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TW-1:0]           now_i,
  input  logic [NUM_BANKS-1:0]    bank_open_i,
  input  logic [NUM_BANKS*TW-1:0] pre_allowed_i,
  input  logic                    queue_busy_i,
  input  logic                    pdn_i,
  input  logic                    sref_i,
  input  logic                    pd_en_i,
  output logic                    prea_o,
  output logic                    ref_o,
  output logic                    wake_o,
  output logic                    lp_enter_o,
  output logic                    lp_kind_o,
  output logic                    act_set_o,
  output logic [TW-1:0]           act_allow_o,
  output logic                    busy_o,
  output logic                    overrun_o
);
  logic [TW-1:0] pre_max, start_at, done_at;
  logic          any_open;

  rrs_pre_max #(.NUM_BANKS(NUM_BANKS), .TW(TW)) u_max (
    .bank_open_i  (bank_open_i),
    .pre_allowed_i(pre_allowed_i),
    .max_o        (pre_max),
    .any_o        (any_open)
  );

  rrs_deadline #(.TW(TW), .T_REFI(T_REFI), .T_RP(T_RP)) u_dl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (ref_o),
    .done_at_i (done_at),
    .start_at_o(start_at),
    .overrun_o (overrun_o)
  );

  rrs_fsm #(
    .TW(TW), .T_RP(T_RP), .T_RFC(T_RFC), .T_XP(T_XP), .T_XS(T_XS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .now_i       (now_i),
    .start_at_i  (start_at),
    .pre_max_i   (pre_max),
    .any_open_i  (any_open),
    .queue_busy_i(queue_busy_i),
    .pdn_i       (pdn_i),
    .sref_i      (sref_i),
    .pd_en_i     (pd_en_i),
    .prea_o      (prea_o),
    .ref_o       (ref_o),
    .wake_o      (wake_o),
    .lp_enter_o  (lp_enter_o),
    .lp_kind_o   (lp_kind_o),
    .act_set_o   (act_set_o),
    .act_allow_o (act_allow_o),
    .done_at_o   (done_at),
    .busy_o      (busy_o)
  );
endmodule

// File: rtl/rrs_chk.sv
module rrs_chk #(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 32,
  parameter int T_RFC     = 20,
  parameter int T_RP      = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [TW-1:0]        now_i,
  input logic [NUM_BANKS-1:0] bank_open_i,
  input logic                 pdn_i,
  input logic                 sref_i,
  input logic                 prea_o,
  input logic                 ref_o,
  input logic                 wake_o,
  input logic                 lp_enter_o,
  input logic                 act_set_o,
  input logic [TW-1:0]        act_allow_o,
  input logic                 busy_o,
  input logic                 overrun_o
);
  // R11
  cmd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prea_o, ref_o, wake_o, lp_enter_o}));

  // R5
  prea_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prea_o |-> (bank_open_i != '0));

  // R5
  prea_allow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prea_o |-> (act_set_o && act_allow_o == now_i + TW'(T_RP)));

  // R6
  ref_allow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |-> (act_set_o && act_allow_o == now_i + TW'(T_RFC)));

  // R6
  ref_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> !ref_o);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R8
  wake_lp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (pdn_i || sref_i));

  // R2
  busy_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prea_o || ref_o || wake_o) |-> busy_o);
endmodule

bind rank_refresh_seq rrs_chk #(
  .NUM_BANKS(NUM_BANKS), .TW(TW), .T_RFC(T_RFC), .T_RP(T_RP)
) u_rrs_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .now_i      (now_i),
  .bank_open_i(bank_open_i),
  .pdn_i      (pdn_i),
  .sref_i     (sref_i),
  .prea_o     (prea_o),
  .ref_o      (ref_o),
  .wake_o     (wake_o),
  .lp_enter_o (lp_enter_o),
  .act_set_o  (act_set_o),
  .act_allow_o(act_allow_o),
  .busy_o     (busy_o),
  .overrun_o  (overrun_o)
);

// File: tb/rank_refresh_seq_test.sv
`timescale 1ns/1ps
module rank_refresh_seq_test;
  localparam int NB = 8;
  localparam int TW = 32;
  localparam int REFI = 200, RFC = 20, RP = 5, XP = 3, XS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] now;
  logic [NB-1:0] bank_open = '0;
  logic [NB*TW-1:0] allowed = '0;
  logic q_busy = 1'b0, pdn = 1'b0, sref = 1'b0, pd_en = 1'b0;
  logic prea, refc, wake, lp_enter, lp_kind, act_set, busy, overrun;
  logic [TW-1:0] act_allow;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) now <= '0; else now <= now + 1;

  rank_refresh_seq #(
    .NUM_BANKS(NB), .TW(TW), .T_REFI(REFI), .T_RFC(RFC),
    .T_RP(RP), .T_XP(XP), .T_XS(XS)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .now_i(now), .bank_open_i(bank_open),
    .pre_allowed_i(allowed), .queue_busy_i(q_busy), .pdn_i(pdn),
    .sref_i(sref), .pd_en_i(pd_en), .prea_o(prea), .ref_o(refc),
    .wake_o(wake), .lp_enter_o(lp_enter), .lp_kind_o(lp_kind),
    .act_set_o(act_set), .act_allow_o(act_allow), .busy_o(busy),
    .overrun_o(overrun)
  );

  task automatic check(input bit ok, input string tag, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_now(input int t);
    while (int'(now) < t) @(negedge clk);
  endtask

  function automatic logic strobe(input int sel);
    case (sel)
      0: return prea;
      1: return refc;
      2: return wake;
      default: return lp_enter;
    endcase
  endfunction

  // first appearance of a strobe must land exactly on exp_at
  task automatic expect_pulse(input int sel, input int exp_at, input string tag,
                              input bit chk_allow, input int exp_allow);
    int seen = -1;
    while (int'(now) <= exp_at + 60) begin
      @(negedge clk);
      if (strobe(sel)) begin seen = int'(now); break; end
    end
    check(seen == exp_at, tag, seen, exp_at);
    if (chk_allow && seen >= 0)
      check(act_set && int'(act_allow) == exp_allow, {tag, " allow"},
            int'(act_allow), exp_allow);
  endtask

  task automatic set_bank(input int b, input bit op, input int t);
    bank_open[b] = op;
    allowed[b*TW +: TW] = TW'(t);
  endtask

  task automatic t_reset_basic;
    @(negedge clk);
    check(!prea && !refc && !wake && !lp_enter && !act_set && !busy && !overrun,
          "R1 reset outputs", {prea, refc, wake, lp_enter, act_set, busy, overrun}, 0);
    wait_now(194);
    check(!busy, "R1 idle before start", busy, 0);
    wait_now(196);
    check(busy, "R2 busy after start", busy, 1);
    expect_pulse(1, 197, "R4 ref without precharge", 1, 197 + RFC);
    wait_now(217);
    check(!lp_enter, "R10 no entry when disabled", lp_enter, 0);
    wait_now(218);
    check(!busy, "R2 idle after completion", busy, 0);
  endtask

  task automatic t_prea;
    set_bank(1, 1, 300);
    set_bank(5, 1, 410);
    set_bank(6, 0, 999);
    pd_en = 1'b1;
    expect_pulse(0, 410, "R5 precharge at latest open bank", 1, 410 + RP);
    expect_pulse(1, 415, "R6 ref tRP after precharge", 1, 415 + RFC);
    wait_now(420);
    q_busy = 1'b1;
    wait_now(435);
    check(!lp_enter, "R10 no entry with busy queue", lp_enter, 0);
    @(negedge clk);
    q_busy = 1'b0;
    bank_open = '0;
  endtask

  task automatic t_drain;
    wait_now(500);
    q_busy = 1'b1;
    wait_now(620);
    q_busy = 1'b0;
    expect_pulse(1, 621, "R3 ref after drain release", 1, 621 + RFC);
    expect_pulse(3, 641, "R10 power-down entry", 0, 0);
    check(!lp_kind, "R10 entry kind", lp_kind, 0);
  endtask

  task automatic t_pdn;
    wait_now(700);
    pdn = 1'b1;
    expect_pulse(2, 796, "R8 wake from power-down", 0, 0);
    expect_pulse(1, 796 + XP + 2, "R8 ref after tXP", 1, 801 + RFC);
    expect_pulse(3, 821, "R9 power-down restored", 0, 0);
    check(!lp_kind, "R9 kind power-down", lp_kind, 0);
    @(negedge clk);
    pdn = 1'b0;
  endtask

  task automatic t_sref;
    wait_now(900);
    sref = 1'b1;
    expect_pulse(2, 996, "R8 wake from self-refresh", 0, 0);
    expect_pulse(1, 996 + XS + 2, "R8 ref after tXS", 1, 1010 + RFC);
    expect_pulse(3, 1030, "R9 self-refresh restored", 0, 0);
    check(lp_kind, "R9 kind self-refresh", lp_kind, 1);
    check(!overrun, "R7 no overrun on time", overrun, 0);
    @(negedge clk);
    sref = 1'b0;
  endtask

  task automatic t_overrun;
    wait_now(1100);
    pd_en = 1'b0;
    set_bank(0, 1, 1400);
    expect_pulse(0, 1400, "R7 late precharge", 1, 1400 + RP);
    wait_now(1404);
    check(!overrun, "R7 overrun low before ref", overrun, 0);
    wait_now(1406);
    check(overrun, "R7 overrun raised", overrun, 1);
    wait_now(1440);
    check(overrun, "R7 overrun sticky", overrun, 1);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_basic();
    t_prea();
    t_drain();
    t_pdn();
    t_sref();
    t_overrun();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    summary();
    $finish;
  end
endmodule